// File: doc/BRIEF.md
# Serial-Load Cartridge Bank Mapper

This block turns a stream of single-bit CPU writes into the bank selection of a game cartridge. The CPU writes to any address from 0x8000 to 0xFFFF. Each ordinary write delivers one bit, taken from data bit 0. After five such writes the block has a 5-bit word. It stores that word in one of four control registers. Bits 14:13 of the address of the fifth write choose the register. A write with data bit 7 set abandons any partial word.

The control registers set the nametable mirroring arrangement. They also set the program-ROM bank for each of the two 16 KB CPU windows (0x8000 and 0xC000), and the character-ROM bank for each of the two 4 KB video windows (0x0000 and 0x1000). The decode depends on the size of the cartridge, so the program-ROM and character-ROM bank counts are inputs. The block holds no ROM. It only produces bank indices, and the surrounding logic uses them to form physical addresses.

Top module: `serial_bank_mapper`

## Requirements
- R1: While reset is low, all outputs read zero, except the mirroring output, which reads code 2. On the first clock after reset is released, the outputs show the boot setting. The control register boots with 16 KB program mode and the switchable window at 0x8000. So the outputs are: mirroring 2, program low bank 0, program high bank = program bank count − 1, character low bank 0 and character high bank 1.
- R2: An accepted write with data bit 7 clear shifts data bit 0 into the next free position, starting at bit 0. Only the fifth such write commits the word, and the outputs change on the clock edge that accepts it. Writes 1 to 4 leave the outputs unchanged, and data bits 6:1 have no effect.
- R3: A write with data bit 7 set discards any partly shifted word. The next five ordinary writes then form a fresh word.
- R4: A bit-7 write to 0x8000–0x9FFF sets bits 2 and 3 of control register 0 and keeps its other bits. A bit-7 write to any other range leaves every register unchanged.
- R5: Writes below 0x8000 are ignored and do not count as one of the five. Address bits 14:13 select the target register: 00 mode/control, 01 character bank A, 10 character bank B, 11 program bank.
- R6: Mirroring output code as a function of control bits 1:0: 00 gives 2 (single screen, lower page), 01 gives 3 (single screen, upper page), 10 gives 0 (vertical), 11 gives 1 (horizontal).
- R7: With control bit 4 clear (8 KB character mode), character low = 2 × (bank A bits 3:0) + offset A, and character high = character low + 1. Offset A is half the character bank count when bank A bit 4 is set, and 0 otherwise. Bank B is ignored in this mode.
- R8: With control bit 4 set (4 KB character mode), character low = bank A bits 3:0 + offset A, and character high = bank B bits 3:0 + offset B. Offset B is half the character bank count when bank B bit 4 is set.
- R9: With control bit 3 clear (32 KB program mode), program low = 2 × (base + program register bits 3:0), and program high = program low + 1.
- R10: With control bit 3 set (16 KB program mode), let S = 2 × base + program register bits 3:0. If control bit 2 is set, program low = S and program high = program bank count − 1. If control bit 2 is clear, program low = 0 and program high = S.
- R11: The base is 0 for carts of fewer than 16 program banks. For carts of 16 to 31 banks, the base is 8 when bank A bit 4 is set and 0 otherwise. For carts of 32 or more banks, the base is 16 × (bank A bit 4) in 8 KB character mode. In 4 KB character mode it is 8 × {bank B bit 4, bank A bit 4}.
- R12: A change of either bank-count input shows in the outputs one clock later, with no write needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data (bit 7: clear, bit 0: serial bit) |
| prg_bank_count | input | PRG_W | Cartridge program ROM size in 16 KB banks |
| chr_bank_count | input | CHR_W | Cartridge character ROM size in 4 KB banks |
| mirror_mode | output | 2 | 0 vertical, 1 horizontal, 2 single lower, 3 single upper |
| prg_bank_lo | output | PRG_W | 16 KB bank at CPU 0x8000 |
| prg_bank_hi | output | PRG_W | 16 KB bank at CPU 0xC000 |
| chr_bank_lo | output | CHR_W | 4 KB bank at video 0x0000 |
| chr_bank_hi | output | CHR_W | 4 KB bank at video 0x1000 |

## Verification
The bench builds the mapper with its default 8-bit bank widths and the default size thresholds of 16 and 32 banks. Because the cart sizes are ports, the bench can drive program counts of 8, 16 and 32 and character counts of 16, 32 and 64 into one build. These values cross both base thresholds and both base formulas for large carts. They also give three different half-size offsets for the character windows. Sequences that interleave ignored writes, abandoned partial words and bit-7 writes to each address range show whether the five-write count survives each kind of disturbance.

// File: rtl/sbm_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types of the serial-load bank mapper.
// Assumes a 16-bit CPU address and an 8-bit data bus.
package sbm_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int SER_LEN   = 5;   // bits per serial word
    localparam int NUM_REGS  = 4;
    localparam int SEL_W     = $clog2(NUM_REGS);

    // register indices (decoded from address bits 14:13)
    localparam int IDX_CTRL  = 0;
    localparam int IDX_CHRA  = 1;
    localparam int IDX_CHRB  = 2;
    localparam int IDX_PRG   = 3;

    // bit positions
    localparam int CTL_AREA  = 2;   // 1: switch window at 0x8000
    localparam int CTL_SIZE  = 3;   // 1: 16 KB program mode
    localparam int CTL_CHR4K = 4;   // 1: 4 KB character mode
    localparam int HALF_SEL  = 4;   // upper-half select in bank registers
    localparam int CLR_BIT   = 7;   // data bit that clears the shifter

    typedef logic [SER_LEN-1:0] ser_word_t;
    typedef ser_word_t [NUM_REGS-1:0] ctl_bank_t;

    localparam ser_word_t CTL_FORCE = ser_word_t'((1 << CTL_AREA) | (1 << CTL_SIZE));
    localparam ctl_bank_t CTL_BOOT  = ctl_bank_t'(CTL_FORCE);

    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORZ   = 2'd1,
        MIR_ONE_LO = 2'd2,
        MIR_ONE_HI = 2'd3
    } mirror_e;
endpackage

// File: rtl/sbm_serial_loader.sv
`timescale 1ns/1ps
// Serial loader: gathers data bit 0 of accepted writes into a word of
// SER_LEN bits, lowest bit first, and flags the write that completes it.
// A write with the clear bit set discards the partial word.
// Assumes one write per strobe cycle. Writes below 0x8000 are not accepted.
module sbm_serial_loader
    import sbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cmt_valid,
    output logic [SEL_W-1:0]  cmt_sel,
    output ser_word_t         cmt_word,
    output logic              clr_hit,
    output logic [SEL_W-1:0]  clr_sel
);
    localparam int CNT_W = $clog2(SER_LEN + 1);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(SER_LEN - 1);

    ser_word_t        acc_q;
    ser_word_t        acc_nx;
    logic [CNT_W-1:0] cnt_q;
    logic             hit;
    logic             shift_en;
    logic [SEL_W-1:0] sel;
    logic             unused_low_bits;

    assign unused_low_bits = ^{wr_addr[ADDR_W-SEL_W-2:0], wr_data[DATA_W-2:1]};

    // Purpose: classify the current write.
    always_comb begin
        hit       = wr_en && wr_addr[ADDR_W-1];
        clr_hit   = hit && wr_data[CLR_BIT];
        shift_en  = hit && !wr_data[CLR_BIT];
        sel       = wr_addr[ADDR_W-2 -: SEL_W];
        cmt_valid = shift_en && (cnt_q == LAST_POS);
        cmt_sel   = sel;
        clr_sel   = sel;
        cmt_word  = acc_nx;
    end

    // Purpose: place the incoming bit at the current fill position.
    for (genvar g = 0; g < SER_LEN; g++) begin : g_fill
        assign acc_nx[g] = (cnt_q == CNT_W'(g)) ? wr_data[0] : acc_q[g];
    end

    // Purpose: accumulator and fill counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (clr_hit || cmt_valid) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (shift_en) begin
            acc_q <= acc_nx;
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sbm_ctl_regs.sv
`timescale 1ns/1ps
// Control register file: four SER_LEN-bit registers. The loader writes a
// completed word into one of them. A clear write aimed at the control
// register forces its window-area and size bits to 1.
// Provides both the stored state and the state that follows this cycle.
module sbm_ctl_regs
    import sbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmt_valid,
    input  logic [SEL_W-1:0] cmt_sel,
    input  ser_word_t        cmt_word,
    input  logic             clr_hit,
    input  logic [SEL_W-1:0] clr_sel,
    output ctl_bank_t        ctl_q,
    output ctl_bank_t        ctl_nx
);
    // Purpose: next register contents from commit and clear events.
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            ctl_nx[i] = ctl_q[i];
            if (cmt_valid && (cmt_sel == SEL_W'(i)))
                ctl_nx[i] = cmt_word;
        end
        if (clr_hit && (clr_sel == SEL_W'(IDX_CTRL)))
            ctl_nx[IDX_CTRL] = ctl_q[IDX_CTRL] | CTL_FORCE;
    end

    // Purpose: register storage with boot values.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_BOOT;
        else        ctl_q <= ctl_nx;
    end
endmodule

// File: rtl/sbm_bank_decode.sv
`timescale 1ns/1ps
// Bank decoder (combinational): maps the control registers and the cart
// sizes to a mirroring code and to program and character bank numbers.
// Program banks are counted in 16 KB units, character banks in 4 KB units.
// The outer base is counted in 32 KB units.
// Assumes PRG_W >= 6 and CHR_W >= 5.
module sbm_bank_decode
    import sbm_pkg::*;
#(
    parameter int PRG_W    = 8,
    parameter int CHR_W    = 8,
    parameter int MID_CART = 16,
    parameter int BIG_CART = 32
) (
    input  ctl_bank_t         ctl,
    input  logic [PRG_W-1:0]  prg_cnt,
    input  logic [CHR_W-1:0]  chr_cnt,
    output logic [1:0]        mir,
    output logic [PRG_W-1:0]  prg_lo,
    output logic [PRG_W-1:0]  prg_hi,
    output logic [CHR_W-1:0]  chr_lo,
    output logic [CHR_W-1:0]  chr_hi
);
    localparam logic [PRG_W-1:0] MID_T     = PRG_W'(MID_CART);
    localparam logic [PRG_W-1:0] BIG_T     = PRG_W'(BIG_CART);
    localparam logic [PRG_W-1:0] BASE_MID  = PRG_W'(MID_CART / 2);
    localparam logic [PRG_W-1:0] BASE_BIG  = PRG_W'(BIG_CART / 2);
    localparam logic [PRG_W-1:0] BASE_STEP = PRG_W'(MID_CART / 2);

    mirror_e          mir_e;
    logic [PRG_W-1:0] base;
    logic [PRG_W-1:0] prg_val;
    logic [PRG_W-1:0] sw16;
    logic [PRG_W-1:0] lo32;
    logic [CHR_W-1:0] half;
    logic [CHR_W-1:0] off_a;
    logic [CHR_W-1:0] off_b;
    logic [CHR_W-1:0] val_a;
    logic [CHR_W-1:0] val_b;
    logic             half_a;
    logic             half_b;
    logic             unused_prg_msb;

    assign unused_prg_msb = ctl[IDX_PRG][SER_LEN-1];

    // Purpose: mirroring code from control bits 1:0.
    always_comb begin
        unique case (ctl[IDX_CTRL][1:0])
            2'b00:   mir_e = MIR_ONE_LO;
            2'b01:   mir_e = MIR_ONE_HI;
            2'b10:   mir_e = MIR_VERT;
            default: mir_e = MIR_HORZ;
        endcase
        mir = mir_e;
    end

    // Purpose: outer program base from cart size and upper-half bits.
    always_comb begin
        half_a = ctl[IDX_CHRA][HALF_SEL];
        half_b = ctl[IDX_CHRB][HALF_SEL];
        base   = '0;
        if (prg_cnt >= BIG_T) begin
            if (!ctl[IDX_CTRL][CTL_CHR4K])
                base = half_a ? BASE_BIG : '0;
            else
                base = BASE_STEP * PRG_W'({half_b, half_a});
        end else if (prg_cnt >= MID_T) begin
            base = half_a ? BASE_MID : '0;
        end
    end

    // Purpose: program window banks for 32 KB and both 16 KB layouts.
    always_comb begin
        prg_val = PRG_W'(ctl[IDX_PRG][3:0]);
        sw16    = (base << 1) + prg_val;
        lo32    = (base + prg_val) << 1;
        if (!ctl[IDX_CTRL][CTL_SIZE]) begin
            prg_lo = lo32;
            prg_hi = lo32 + PRG_W'(1);
        end else if (ctl[IDX_CTRL][CTL_AREA]) begin
            prg_lo = sw16;
            prg_hi = prg_cnt - PRG_W'(1);
        end else begin
            prg_lo = '0;
            prg_hi = sw16;
        end
    end

    // Purpose: character window banks for 8 KB and 4 KB modes.
    always_comb begin
        half  = chr_cnt >> 1;
        off_a = ctl[IDX_CHRA][HALF_SEL] ? half : '0;
        off_b = ctl[IDX_CHRB][HALF_SEL] ? half : '0;
        val_a = CHR_W'(ctl[IDX_CHRA][3:0]);
        val_b = CHR_W'(ctl[IDX_CHRB][3:0]);
        if (ctl[IDX_CTRL][CTL_CHR4K]) begin
            chr_lo = val_a + off_a;
            chr_hi = val_b + off_b;
        end else begin
            chr_lo = (val_a << 1) + off_a;
            chr_hi = ((val_a << 1) + off_a) + CHR_W'(1);
        end
    end
endmodule

// File: rtl/serial_bank_mapper.sv
`timescale 1ns/1ps
// Serial-load cartridge bank mapper (top). It connects the serial loader,
// the control registers and the bank decoder, and registers every output.
// The outputs follow the register state of the same edge, so a committed
// word shows in the cycle after the fifth write.
// Assumes the cart sizes are stable or change only between frames.
module serial_bank_mapper
    import sbm_pkg::*;
#(
    parameter int PRG_W    = 8,
    parameter int CHR_W    = 8,
    parameter int MID_CART = 16,
    parameter int BIG_CART = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [PRG_W-1:0]  prg_bank_count,
    input  logic [CHR_W-1:0]  chr_bank_count,
    output logic [1:0]        mirror_mode,
    output logic [PRG_W-1:0]  prg_bank_lo,
    output logic [PRG_W-1:0]  prg_bank_hi,
    output logic [CHR_W-1:0]  chr_bank_lo,
    output logic [CHR_W-1:0]  chr_bank_hi
);
    logic             cmt_valid;
    logic [SEL_W-1:0] cmt_sel;
    ser_word_t        cmt_word;
    logic             clr_hit;
    logic [SEL_W-1:0] clr_sel;
    ctl_bank_t        ctl_q;
    ctl_bank_t        ctl_nx;
    logic [1:0]       mir_d;
    logic [PRG_W-1:0] prg_lo_d;
    logic [PRG_W-1:0] prg_hi_d;
    logic [CHR_W-1:0] chr_lo_d;
    logic [CHR_W-1:0] chr_hi_d;

    sbm_serial_loader u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cmt_valid (cmt_valid),
        .cmt_sel   (cmt_sel),
        .cmt_word  (cmt_word),
        .clr_hit   (clr_hit),
        .clr_sel   (clr_sel)
    );

    sbm_ctl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmt_valid (cmt_valid),
        .cmt_sel   (cmt_sel),
        .cmt_word  (cmt_word),
        .clr_hit   (clr_hit),
        .clr_sel   (clr_sel),
        .ctl_q     (ctl_q),
        .ctl_nx    (ctl_nx)
    );

    sbm_bank_decode #(
        .PRG_W    (PRG_W),
        .CHR_W    (CHR_W),
        .MID_CART (MID_CART),
        .BIG_CART (BIG_CART)
    ) u_decode (
        .ctl     (ctl_nx),
        .prg_cnt (prg_bank_count),
        .chr_cnt (chr_bank_count),
        .mir     (mir_d),
        .prg_lo  (prg_lo_d),
        .prg_hi  (prg_hi_d),
        .chr_lo  (chr_lo_d),
        .chr_hi  (chr_hi_d)
    );

    // Purpose: output registers, cleared while in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mirror_mode <= MIR_ONE_LO;
            prg_bank_lo <= '0;
            prg_bank_hi <= '0;
            chr_bank_lo <= '0;
            chr_bank_hi <= '0;
        end else begin
            mirror_mode <= mir_d;
            prg_bank_lo <= prg_lo_d;
            prg_bank_hi <= prg_hi_d;
            chr_bank_lo <= chr_lo_d;
            chr_bank_hi <= chr_hi_d;
        end
    end
endmodule

// File: rtl/sbm_checker.sv
`timescale 1ns/1ps
// Checker for the serial-load bank mapper. It relates the write port,
// the control-register mode bits and the registered outputs over time.
// Attached to every instance of the top module by the bind below.
module sbm_checker #(
    parameter int PRG_W = 8,
    parameter int CHR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [15:0]      wr_addr,
    input logic             clr_bit,
    input logic [PRG_W-1:0] prg_bank_count,
    input logic [CHR_W-1:0] chr_bank_count,
    input logic [2:0]       mode_bits,   // {chr 4 KB, prg 16 KB, area}
    input logic [1:0]       mirror_mode,
    input logic [PRG_W-1:0] prg_bank_lo,
    input logic [PRG_W-1:0] prg_bank_hi,
    input logic [CHR_W-1:0] chr_bank_lo,
    input logic [CHR_W-1:0] chr_bank_hi
);
    // R2: without a write or size change, the outputs hold
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n) && $stable(prg_bank_count) && $stable(chr_bank_count))
        |=> $stable({mirror_mode, prg_bank_lo, prg_bank_hi, chr_bank_lo, chr_bank_hi}));

    // R4: a clear write to the control range forces 16 KB mode at 0x8000
    assert_ctrl_force_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && clr_bit && wr_addr >= 16'h8000 && wr_addr <= 16'h9FFF)
        |=> (mode_bits[1:0] == 2'b11));

    // R7: in 8 KB character mode the two windows are consecutive
    assert_chr_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !mode_bits[2]) |-> (chr_bank_hi == chr_bank_lo + CHR_W'(1)));

    // R9: in 32 KB program mode the two windows are consecutive
    assert_prg_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !mode_bits[1]) |-> (prg_bank_hi == prg_bank_lo + PRG_W'(1)));

    // R10: switched window at 0x8000 leaves the last bank at 0xC000
    assert_last_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode_bits[1] && mode_bits[0])
        |-> (prg_bank_hi == $past(prg_bank_count) - PRG_W'(1)));

    // R10: switched window at 0xC000 leaves the first bank at 0x8000
    assert_first_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode_bits[1] && !mode_bits[0]) |-> (prg_bank_lo == '0));
endmodule

bind serial_bank_mapper sbm_checker #(
    .PRG_W (PRG_W),
    .CHR_W (CHR_W)
) u_sbm_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .clr_bit        (wr_data[7]),
    .prg_bank_count (prg_bank_count),
    .chr_bank_count (chr_bank_count),
    .mode_bits      (ctl_q[0][4:2]),
    .mirror_mode    (mirror_mode),
    .prg_bank_lo    (prg_bank_lo),
    .prg_bank_hi    (prg_bank_hi),
    .chr_bank_lo    (chr_bank_lo),
    .chr_bank_hi    (chr_bank_hi)
);

// File: tb/serial_bank_mapper_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the serial-load bank mapper: one task per scenario.
module serial_bank_mapper_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] prg_cnt = 8'd8;
    logic [7:0] chr_cnt = 8'd16;
    logic [1:0] mir;
    logic [7:0] plo, phi, clo, chi;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    serial_bank_mapper dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .prg_bank_count (prg_cnt),
        .chr_bank_count (chr_cnt),
        .mirror_mode    (mir),
        .prg_bank_lo    (plo),
        .prg_bank_hi    (phi),
        .chr_bank_lo    (clo),
        .chr_bank_hi    (chi)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_all(input string req, input int m, input int pl,
                              input int ph, input int cl, input int ch);
        check({req, " mirror"}, int'(mir), m);
        check({req, " prg_lo"}, int'(plo), pl);
        check({req, " prg_hi"}, int'(phi), ph);
        check({req, " chr_lo"}, int'(clo), cl);
        check({req, " chr_hi"}, int'(chi), ch);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // upper data bits carry noise that must not matter (R2)
    task automatic load(input logic [15:0] a, input logic [4:0] v);
        for (int i = 0; i < 5; i++) wr(a, {1'b0, 6'h2A, v[i]});
    endtask

    task automatic set_counts(input logic [7:0] p, input logic [7:0] c);
        @(negedge clk);
        prg_cnt = p; chr_cnt = c;
        @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        expect_all("R1 in reset", 2, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_all("R1 boot", 2, 0, 7, 0, 1);
    endtask

    task automatic t_mirror;
        load(16'h8000, 5'b01110);
        expect_all("R6 vertical", 0, 0, 7, 0, 1);
        for (int i = 0; i < 4; i++) wr(16'h8000, 8'h7F);
        check("R2 four writes no commit", int'(mir), 0);
        wr(16'h8000, 8'h7E);
        check("R2 R6 fifth write horizontal", int'(mir), 1);
        load(16'h8000, 5'b01101);
        check("R6 single upper", int'(mir), 3);
        load(16'h8000, 5'b01100);
        check("R6 single lower", int'(mir), 2);
        load(16'h8000, 5'b01111);
        check("R6 horizontal again", int'(mir), 1);
    endtask

    task automatic t_partial;
        for (int i = 0; i < 3; i++) wr(16'h8000, 8'h00);
        wr(16'h8000, 8'h80);
        check("R4 clear keeps mirroring", int'(mir), 1);
        load(16'h8000, 5'b01110);
        check("R3 fresh word after clear", int'(mir), 0);
    endtask

    task automatic t_addr;
        wr(16'hE000, 8'h01);
        wr(16'h7FFF, 8'h01);
        wr(16'hE000, 8'h01);
        wr(16'hE000, 8'h00);
        wr(16'hE000, 8'h00);
        check("R5 low write not counted", int'(plo), 0);
        wr(16'hFFFF, 8'h00);
        expect_all("R5 R10 program bank 3", 0, 3, 7, 0, 1);
    endtask

    task automatic t_ctrl_force;
        load(16'h8000, 5'b00010);
        expect_all("R9 32 KB", 0, 6, 7, 0, 1);
        wr(16'hA000, 8'h80);
        expect_all("R4 clear elsewhere no effect", 0, 6, 7, 0, 1);
        wr(16'h9FFF, 8'h80);
        expect_all("R4 clear forces 16 KB", 0, 3, 7, 0, 1);
    endtask

    task automatic t_area0;
        load(16'h8000, 5'b01010);
        expect_all("R10 switch at 0xC000", 0, 0, 3, 0, 1);
    endtask

    task automatic t_base;
        load(16'h8000, 5'b00010);
        load(16'hA000, 5'b10000);
        expect_all("R7 half offset", 0, 6, 7, 8, 9);
        set_counts(8'd16, 8'd16);
        expect_all("R11 R12 mid cart base", 0, 22, 23, 8, 9);
        set_counts(8'd32, 8'd16);
        expect_all("R11 big cart 8 KB chr", 0, 38, 39, 8, 9);
        load(16'h8000, 5'b01110);
        expect_all("R10 R11 16 KB with base", 0, 35, 31, 8, 9);
        load(16'h8000, 5'b10010);
        expect_all("R11 big cart 4 KB chr", 0, 22, 23, 8, 0);
        load(16'hC000, 5'b10101);
        expect_all("R11 R8 both upper bits", 0, 54, 55, 8, 13);
        set_counts(8'd8, 8'd16);
        expect_all("R11 small cart", 0, 6, 7, 8, 13);
    endtask

    task automatic t_chr;
        load(16'hBFFF, 5'b00110);
        expect_all("R8 4 KB windows", 0, 6, 7, 6, 13);
        load(16'h8000, 5'b00010);
        expect_all("R7 8 KB pair", 0, 6, 7, 12, 13);
        load(16'hDFFF, 5'b00001);
        expect_all("R7 bank B ignored", 0, 6, 7, 12, 13);
        set_counts(8'd8, 8'd32);
        load(16'hA000, 5'b10010);
        expect_all("R7 half of 32", 0, 6, 7, 20, 21);
        set_counts(8'd8, 8'd64);
        expect_all("R12 chr size change", 0, 6, 7, 36, 37);
    endtask

    initial begin
        t_reset();
        t_mirror();
        t_partial();
        t_addr();
        t_ctrl_force();
        t_area0();
        t_base();
        t_chr();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule